// File: doc/BRIEF.md
# Interrupt Cause Moderation Controller

This block collects interrupt causes from the receive and transmit sides of a network controller and drives one interrupt line toward the host. Every posted cause is latched in a pending-cause register. The line rises only for causes that software has enabled in a mask. A throttle interval, counted in units of 1024 ns, limits how often ordinary posts may raise the line. A post that carries the immediate flag skips the throttle.

Four delay timers run beside the cause logic. Two serve the receive path (per-packet delay and absolute delay) and two serve the transmit path. When a timer runs out, the block pulses a flush request to the matching descriptor engine, with the alignment mask taken as zero. On the next clock edge it posts the matching cause with the immediate flag. A completed transmit descriptor writeback posts the transmit-done cause as an ordinary, throttled post. The host reads the pending register through a read strobe. That read clears all pending bits and lowers the line.

Top module: `irq_moderator`

## Requirements
- R1: A bit set in `post_vec` on a clock edge appears set in `cause_q` after that edge. Bit i of `cause_q` stands for cause i, and pending bits accumulate until a read.
- R2: A mask bit of 1 enables its cause. An enabled, non-immediate post with no throttle interval running raises `irq` on the same edge that latches it. A post to a masked cause sets its pending bit and leaves `irq` low.
- R3: When `irq` rises and the throttle setting T is nonzero, an interval of T*UNIT_CYCLES cycles starts. A non-immediate post during that interval only sets pending bits. On the edge that ends the interval, `irq` rises if any enabled cause is pending, and a new interval starts. A setting of 0 disables throttling.
- R4: A post with `post_now` high raises `irq` for enabled causes even while a throttle interval is running.
- R5: Each delay timer holds its own reload value (written through `tmr_cfg_we[i]`). A start on edge s gives a one-cycle expiry D edges later, where D is the reload value. A new start reloads a running timer. A reload value of 0 never expires. Reset stops all timers. Timer index 0 is receive per-packet, 1 is receive absolute, 2 is transmit per-packet and 3 is transmit absolute.
- R6: Expiry of timer 0 or 1 drives `rx_flush` high for that cycle. On the next edge the block sets cause bit RXT_BIT and, if that bit is enabled, raises `irq` regardless of the throttle.
- R7: Expiry of timer 2 or 3 drives `tx_flush` high for that cycle. On the next edge the block sets cause bit TXDW_BIT and, if that bit is enabled, raises `irq` regardless of the throttle.
- R8: A `txwb_done` strobe posts cause bit TXDW_BIT as a non-immediate post, so the throttle applies to it.
- R9: A mask write raises `irq` if any cause enabled by the new mask is pending. It lowers `irq` if no enabled cause is pending.
- R10: A `cause_rd` strobe shows the pending bits on `cause_q` in that cycle, then clears them and lowers `irq`. A post on the same edge survives the clear and is handled as usual.
- R11: After reset, `cause_q` is 0, the mask is 0, `irq`, `rx_flush` and `tx_flush` are low, and no timer or throttle interval is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_vec | input | N_CAUSE | Cause post strobes, one per cause |
| post_now | input | 1 | Immediate flag for the causes in `post_vec` |
| txwb_done | input | 1 | A transmit descriptor writeback completed |
| mask_we | input | 1 | Write `mask_wdata` to the enable mask |
| mask_wdata | input | N_CAUSE | New enable mask (1 enables) |
| thr_we | input | 1 | Write `thr_wdata` to the throttle setting |
| thr_wdata | input | THR_W | Throttle interval in 1024 ns units |
| cause_rd | input | 1 | Read-and-clear strobe for the pending register |
| cause_q | output | N_CAUSE | Pending-cause register |
| tmr_cfg_we | input | 4 | Per-timer reload-value write strobes |
| tmr_cfg_data | input | TMR_W | Reload value |
| tmr_start | input | 4 | Per-timer start or restart strobes |
| rx_flush | output | 1 | Flush request to the receive descriptor engine |
| tx_flush | output | 1 | Flush request to the transmit descriptor engine |
| irq | output | 1 | Interrupt line to the host |

## Verification
The bench checks the exact edge on which a throttle interval ends. It posts a cause one cycle into the interval and expects the line on the closing edge and not one cycle before or after. A prescaler or counter that is off by one fails here. It also checks that a timer expiry still gets through while an interval runs: the flush pulse has to come one cycle before the line. A design that throttled immediate posts, or that posted before flushing, would fail this. Other checks cover a restarted timer (a design that ignores the restart expires too early), a zero reload value (which must never expire), a read on the same edge as a post (a design that loses the post shows zero), and a mask write that leaves only masked causes pending (the line must drop).

// File: rtl/irq_mod_pkg.sv
package irq_mod_pkg;
   // Delay timer slots; the index picks which descriptor engine is flushed
   typedef enum logic [1:0] {
      TMR_RX_PKT = 2'd0,
      TMR_RX_ABS = 2'd1,
      TMR_TX_PKT = 2'd2,
      TMR_TX_ABS = 2'd3
   } tmr_idx_e;

   localparam int NUM_TMR = 4;
endpackage

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_we,
   input  logic [W-1:0] cfg_data,
   input  logic         start,
   output logic         expire
);
   logic [W-1:0] reload_q;
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         cnt_q    <= '0;
         expire   <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (cfg_we)
            reload_q <= cfg_data;
         if (start)
            cnt_q <= reload_q;
         else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
            if (cnt_q == W'(1))
               expire <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
   parameter int CW         = 16,
   parameter int UNIT_CYCLES = 205
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] load_val,
   output logic          active,
   output logic          done
);
   localparam int PW = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
   localparam logic [PW-1:0] PRE_TOP = PW'(UNIT_CYCLES - 1);

   logic [CW-1:0] units_q;
   logic [PW-1:0] pre_q;

   assign active = (units_q != '0);
   assign done   = active && (units_q == CW'(1)) && (pre_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         units_q <= '0;
         pre_q   <= '0;
      end else if (start) begin
         units_q <= load_val;
         pre_q   <= PRE_TOP;
      end else if (active) begin
         if (pre_q == '0) begin
            pre_q   <= PRE_TOP;
            units_q <= units_q - CW'(1);
         end else begin
            pre_q <= pre_q - PW'(1);
         end
      end
   end
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator #(
   parameter int N_CAUSE     = 8,
   parameter int RXT_BIT     = 7,
   parameter int TXDW_BIT    = 0,
   parameter int TMR_W       = 16,
   parameter int THR_W       = 16,
   parameter int UNIT_CYCLES = 205
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CAUSE-1:0] post_vec,
   input  logic               post_now,
   input  logic               txwb_done,
   input  logic               mask_we,
   input  logic [N_CAUSE-1:0] mask_wdata,
   input  logic               thr_we,
   input  logic [THR_W-1:0]   thr_wdata,
   input  logic               cause_rd,
   output logic [N_CAUSE-1:0] cause_q,
   input  logic [3:0]         tmr_cfg_we,
   input  logic [TMR_W-1:0]   tmr_cfg_data,
   input  logic [3:0]         tmr_start,
   output logic               rx_flush,
   output logic               tx_flush,
   output logic               irq
);
   import irq_mod_pkg::*;

   if (N_CAUSE < 2) begin : g_bad_n
      $error("N_CAUSE must be at least 2");
   end
   if (RXT_BIT >= N_CAUSE || TXDW_BIT >= N_CAUSE || RXT_BIT == TXDW_BIT) begin : g_bad_bits
      $error("RXT_BIT and TXDW_BIT must be distinct and below N_CAUSE");
   end
   if (UNIT_CYCLES < 1) begin : g_bad_unit
      $error("UNIT_CYCLES must be at least 1");
   end

   logic [NUM_TMR-1:0] tmr_exp;
   logic [N_CAUSE-1:0] mask_q;
   logic [THR_W-1:0]   thr_q;
   logic [N_CAUSE-1:0] post_all, imm_all, pend_n, eff_mask;
   logic               thr_active, thr_done, thr_start;
   logic               raise, hit_n;

   // Delay timers, one per slot
   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      irq_delay_timer #(.W(TMR_W)) u_tmr (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg_we  (tmr_cfg_we[t]),
         .cfg_data(tmr_cfg_data),
         .start   (tmr_start[t]),
         .expire  (tmr_exp[t])
      );
   end

   assign rx_flush = tmr_exp[TMR_RX_PKT] | tmr_exp[TMR_RX_ABS];
   assign tx_flush = tmr_exp[TMR_TX_PKT] | tmr_exp[TMR_TX_ABS];

   irq_throttle #(.CW(THR_W), .UNIT_CYCLES(UNIT_CYCLES)) u_thr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (thr_start),
      .load_val(thr_q),
      .active  (thr_active),
      .done    (thr_done)
   );

   // Merge the post sources; timer expiry posts bypass the throttle
   always_comb begin
      for (int i = 0; i < N_CAUSE; i++) begin
         post_all[i] = post_vec[i]
                     | ((i == TXDW_BIT) && (txwb_done || tx_flush))
                     | ((i == RXT_BIT) && rx_flush);
         imm_all[i]  = (post_now && post_vec[i])
                     | ((i == TXDW_BIT) && tx_flush)
                     | ((i == RXT_BIT) && rx_flush);
      end
   end

   assign eff_mask = mask_we ? mask_wdata : mask_q;
   assign pend_n   = (cause_rd ? '0 : cause_q) | post_all;
   assign hit_n    = |(pend_n & eff_mask);

   assign raise = (|(imm_all & eff_mask))
                | ((|(post_all & eff_mask)) && !thr_active)
                | (thr_done && hit_n)
                | (mask_we && hit_n);

   assign thr_start = raise && (!thr_active || thr_done) && (thr_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
         mask_q  <= '0;
         thr_q   <= '0;
         irq     <= 1'b0;
      end else begin
         cause_q <= pend_n;
         if (mask_we)
            mask_q <= mask_wdata;
         if (thr_we)
            thr_q <= thr_wdata;
         if (raise)
            irq <= 1'b1;
         else if (cause_rd || (mask_we && !hit_n))
            irq <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_moderator_chk.sv
module irq_moderator_chk #(
   parameter int N_CAUSE  = 8,
   parameter int RXT_BIT  = 7,
   parameter int TXDW_BIT = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_CAUSE-1:0] post_vec,
   input logic               txwb_done,
   input logic               mask_we,
   input logic [N_CAUSE-1:0] mask_wdata,
   input logic [N_CAUSE-1:0] mask_q,
   input logic               cause_rd,
   input logic [N_CAUSE-1:0] cause_q,
   input logic               rx_flush,
   input logic               tx_flush,
   input logic               irq
);
   logic quiet;
   assign quiet = (post_vec == '0) && !txwb_done && !rx_flush && !tx_flush;

   // R10
   rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cause_rd && quiet |=> (cause_q == '0) && !irq);

   // R6
   rx_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> cause_q[RXT_BIT]);

   // R6
   rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush && mask_q[RXT_BIT] && !mask_we |=> irq);

   // R7
   tx_post_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_flush |=> cause_q[TXDW_BIT]);

   // R2
   irq_backed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> |(cause_q & mask_q));

   // R9
   mask_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we && quiet && !cause_rd && ((cause_q & mask_wdata) == '0) |=> !irq);
endmodule

bind irq_moderator irq_moderator_chk #(
   .N_CAUSE(N_CAUSE), .RXT_BIT(RXT_BIT), .TXDW_BIT(TXDW_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .post_vec(post_vec), .txwb_done(txwb_done),
   .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_q(mask_q),
   .cause_rd(cause_rd), .cause_q(cause_q), .rx_flush(rx_flush),
   .tx_flush(tx_flush), .irq(irq)
);

// File: tb/test_irq_moderator.sv
`timescale 1ns/1ps
module test_irq_moderator;
   localparam int N = 8;
   localparam int TW = 8;
   localparam int HW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  post_vec = '0;
   logic          post_now = 1'b0;
   logic          txwb_done = 1'b0;
   logic          mask_we = 1'b0;
   logic [N-1:0]  mask_wdata = '0;
   logic          thr_we = 1'b0;
   logic [HW-1:0] thr_wdata = '0;
   logic          cause_rd = 1'b0;
   logic [N-1:0]  cause_q;
   logic [3:0]    tmr_cfg_we = '0;
   logic [TW-1:0] tmr_cfg_data = '0;
   logic [3:0]    tmr_start = '0;
   logic          rx_flush, tx_flush, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_moderator #(
      .N_CAUSE(N), .RXT_BIT(7), .TXDW_BIT(0),
      .TMR_W(TW), .THR_W(HW), .UNIT_CYCLES(4)
   ) i_irq_moderator (
      .clk(clk), .rst_n(rst_n), .post_vec(post_vec), .post_now(post_now),
      .txwb_done(txwb_done), .mask_we(mask_we), .mask_wdata(mask_wdata),
      .thr_we(thr_we), .thr_wdata(thr_wdata), .cause_rd(cause_rd),
      .cause_q(cause_q), .tmr_cfg_we(tmr_cfg_we), .tmr_cfg_data(tmr_cfg_data),
      .tmr_start(tmr_start), .rx_flush(rx_flush), .tx_flush(tx_flush), .irq(irq)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic set_mask(input logic [N-1:0] m);
      mask_we = 1'b1; mask_wdata = m; step(); mask_we = 1'b0;
   endtask

   task automatic set_thr(input logic [HW-1:0] v);
      thr_we = 1'b1; thr_wdata = v; step(); thr_we = 1'b0;
   endtask

   task automatic do_read();
      cause_rd = 1'b1; step(); cause_rd = 1'b0;
   endtask

   task automatic post(input logic [N-1:0] v, input logic now);
      post_vec = v; post_now = now; step(); post_vec = '0; post_now = 1'b0;
   endtask

   task automatic t_reset();
      chk("R11", "irq", 32'(irq), 0);
      chk("R11", "cause", 32'(cause_q), 0);
      chk("R11", "flush", 32'({rx_flush, tx_flush}), 0);
      post(8'h08, 1'b0);
      chk("R11", "mask all off irq", 32'(irq), 0);
      do_read();
   endtask

   task automatic t_masked_post();
      post(8'h08, 1'b0);
      chk("R1", "pending bit3", 32'(cause_q), 32'h08);
      chk("R2", "masked no irq", 32'(irq), 0);
      post(8'h02, 1'b0);
      chk("R1", "accumulate", 32'(cause_q), 32'h0a);
      do_read();
      chk("R10", "read clears", 32'(cause_q), 0);
   endtask

   task automatic t_unmasked_post();
      set_mask(8'hff);
      set_thr(0);
      post(8'h04, 1'b0);
      chk("R2", "irq raised", 32'(irq), 1);
      do_read();
      chk("R10", "irq dropped", 32'(irq), 0);
      chk("R10", "cleared", 32'(cause_q), 0);
      cause_rd = 1'b1; post_vec = 8'h02; step(); cause_rd = 1'b0; post_vec = '0;
      chk("R10", "post kept on read", 32'(cause_q), 32'h02);
      chk("R10", "post on read raises", 32'(irq), 1);
      do_read();
   endtask

   task automatic t_throttle();
      set_thr(3);
      post(8'h04, 1'b0);                 // edge e
      chk("R3", "first post raises", 32'(irq), 1);
      do_read();                         // e+1
      post(8'h10, 1'b0);                 // e+2
      chk("R3", "held in interval", 32'(irq), 0);
      chk("R3", "pending in interval", 32'(cause_q), 32'h10);
      repeat (9) step();                 // e+11
      chk("R3", "not before end", 32'(irq), 0);
      step();                            // e+12
      chk("R3", "raised at end", 32'(irq), 1);
      do_read();                         // e+13
      post(8'h20, 1'b1);                 // e+14, interval running
      chk("R4", "immediate bypasses", 32'(irq), 1);
      set_thr(0);
      do_read();
      repeat (14) step();
      chk("R3", "idle end no raise", 32'(irq), 0);
   endtask

   task automatic t_mask_write();
      set_mask(8'h00);
      post(8'h08, 1'b0);
      chk("R9", "masked pend", 32'(irq), 0);
      set_mask(8'h08);
      chk("R9", "unmask raises", 32'(irq), 1);
      set_mask(8'h00);
      chk("R9", "mask drops", 32'(irq), 0);
      chk("R9", "pend kept", 32'(cause_q), 32'h08);
      do_read();
   endtask

   task automatic t_rx_timer();
      set_mask(8'h80);
      tmr_cfg_we = 4'b0001; tmr_cfg_data = 8'd5; step(); tmr_cfg_we = '0;
      tmr_start = 4'b0001; step(); tmr_start = '0;     // edge s
      repeat (3) step();                               // s+3
      step();                                          // s+4
      chk("R5", "no early expiry", 32'(rx_flush), 0);
      step();                                          // s+5
      chk("R5", "expiry pulse", 32'(rx_flush), 1);
      chk("R6", "post after flush", 32'({irq, cause_q[7]}), 0);
      step();                                          // s+6
      chk("R5", "one cycle pulse", 32'(rx_flush), 0);
      chk("R6", "rxt pending", 32'(cause_q), 32'h80);
      chk("R6", "rxt irq", 32'(irq), 1);
      do_read();
      // restart: start at s, restart at s+2, expiry at s+7
      tmr_start = 4'b0001; step(); tmr_start = '0;     // s
      step();                                          // s+1
      tmr_start = 4'b0001; step(); tmr_start = '0;     // s+2
      begin
         logic seen;
         seen = 1'b0;
         for (int k = 3; k <= 6; k++) begin
            step();
            seen = seen | rx_flush;
         end
         chk("R5", "restart delays", 32'(seen), 0);
      end
      step();                                          // s+7
      chk("R5", "restart expiry", 32'(rx_flush), 1);
      step();
      do_read();
      // zero reload never expires
      tmr_cfg_we = 4'b0010; tmr_cfg_data = 8'd0; step(); tmr_cfg_we = '0;
      tmr_start = 4'b0010; step(); tmr_start = '0;
      begin
         logic seen;
         seen = 1'b0;
         for (int k = 0; k < 10; k++) begin
            step();
            seen = seen | rx_flush;
         end
         chk("R5", "zero never expires", 32'(seen), 0);
      end
   endtask

   task automatic t_tx_timer();
      set_mask(8'h01);
      set_thr(3);
      post(8'h01, 1'b0);           // starts an interval
      do_read();
      tmr_cfg_we = 4'b1000; tmr_cfg_data = 8'd3; step(); tmr_cfg_we = '0;
      tmr_start = 4'b1000; step(); tmr_start = '0;     // s
      step(); step();                                  // s+2
      chk("R7", "no early flush", 32'(tx_flush), 0);
      step();                                          // s+3
      chk("R7", "tx flush", 32'(tx_flush), 1);
      chk("R7", "irq after flush", 32'(irq), 0);
      step();                                          // s+4
      chk("R7", "txdw pending", 32'(cause_q), 32'h01);
      chk("R7", "irq despite interval", 32'(irq), 1);
      set_thr(0);
      do_read();
      repeat (14) step();
   endtask

   task automatic t_txwb();
      set_thr(2);
      txwb_done = 1'b1; step(); txwb_done = 1'b0;       // e
      chk("R8", "writeback raises", 32'(irq), 1);
      do_read();                                        // e+1
      txwb_done = 1'b1; step(); txwb_done = 1'b0;       // e+2
      chk("R8", "writeback throttled", 32'(irq), 0);
      chk("R8", "writeback pending", 32'(cause_q), 32'h01);
      repeat (5) step();                                // e+7
      chk("R8", "still held", 32'(irq), 0);
      step();                                           // e+8
      chk("R8", "raised at end", 32'(irq), 1);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_masked_post();
      t_unmasked_post();
      t_throttle();
      t_mask_write();
      t_rx_timer();
      t_tx_timer();
      t_txwb();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule